// File: doc/BRIEF.md
# Serial Converter Word Writer

This block sits on the host side of a three-wire link to a 16-bit serial-input converter. A parallel sample arrives through a valid/ready handshake. The block then drives a divided serial clock and puts out the sample on a data line, most significant bit first. After the last bit it raises and then drops a latch-enable line. The converter copies its shift register into the output register on that falling edge.

The serial clock is made from the system clock by a half-period divider. The divider ratio is a parameter, and an elaboration check rejects any ratio that gives a serial period shorter than 100 ns at the stated system clock frequency. Latch enable has ordering rules between words: high for a full serial period before it falls, and low for a full serial period after. It also stays low through the first serial clock of the next word. The block meets these rules by parking both lines low when idle and by keeping ready low until the low phase of latch enable has run its course.

Samples are passed through unchanged as two's complement codes. 0x7FFF is positive full scale, 0x8000 is negative full scale, 0x0000 is bipolar zero and 0xFFFF is one step below zero.

Top module: `sdw_word_writer`

## Requirements
- R1: After reset, dac_sclk, dac_le, dac_sdata and word_done are 0 and in_ready is 1.
- R2: A sample is taken at a rising clk edge where in_valid and in_ready are both 1. in_ready then stays 0 until the word has finished, and in_valid pulses while in_ready is 0 start no word.
- R3: Each word produces exactly WORD_W (16) rising edges of dac_sclk, carrying in_data bit 15 first down to bit 0 last.
- R4: dac_sclk stays high for exactly HALF_DIV clk cycles each time. Between rising edges within a word it stays low for exactly HALF_DIV cycles. A HALF_DIV whose serial period 2*HALF_DIV*1000/SYS_CLK_MHZ ns is below MIN_SCLK_NS is rejected at elaboration.
- R5: dac_sdata never changes on the clk edge where dac_sclk rises. It changes only while dac_sclk is low.
- R6: dac_le is 0 during all serial clocks of a word. It rises with dac_sclk low after the last bit, and stays high for exactly 2*HALF_DIV cycles before it falls.
- R7: After dac_le falls it stays low for 2*HALF_DIV cycles. in_ready then returns, with word_done high for that one cycle. This is exactly 36*HALF_DIV cycles after the accepting edge.
- R8: While idle, dac_sclk and dac_le are parked at 0, so dac_le is low when the next word's first serial clock occurs.
- R9: The word delivered at the dac_le falling edge equals the accepted sample for the full-scale, zero and minus-one codes and for arbitrary patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | WORD_W | Two's complement sample |
| dac_sclk | output | 1 | Divided serial clock |
| dac_sdata | output | 1 | Serial data, MSB first |
| dac_le | output | 1 | Latch enable, converter loads on its fall |
| word_done | output | 1 | One-cycle pulse when a word is complete |

## Verification
Counted from the accepting edge, the first serial rising edge is due HALF_DIV cycles later and latch enable rises at 32*HALF_DIV. It falls at 34*HALF_DIV, and ready returns with the done pulse at 36*HALF_DIV. The driver counts cycles from acceptance and samples in_ready, word_done and the parked lines on the falling clk edge after that count. The monitor decodes the link from level changes it sees on falling clk edges. It compares each run length with HALF_DIV or 2*HALF_DIV when the level changes, and pops the expected word from the scoreboard queue at each latch-enable fall.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_LE_HI = 2'd2,
      ST_LE_LO = 2'd3
   } sdw_state_e;
endpackage

// File: rtl/sdw_half_tick.sv
module sdw_half_tick #(
   parameter int HALF_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sdw_shift_out.sv
module sdw_shift_out #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] data,
   input  logic              shift,
   input  logic              drive,
   output logic              sdata
);
   logic [WORD_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sreg <= '0;
      else if (load)   sreg <= data;
      else if (shift)  sreg <= {sreg[WORD_W-2:0], 1'b0};
   end

   assign sdata = drive & sreg[WORD_W-1];
endmodule

// File: rtl/sdw_sequencer.sv
module sdw_sequencer
   import sdw_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic ready,
   output logic running,
   output logic shifting,
   output logic shift_en,
   output logic sclk,
   output logic le,
   output logic done
);
   localparam int BCW = $clog2(WORD_W);

   sdw_state_e     state;
   logic           ph;
   logic [BCW-1:0] bitcnt;

   assign ready    = (state == ST_IDLE);
   assign running  = (state != ST_IDLE);
   assign shifting = (state == ST_SHIFT);
   assign shift_en = shifting && tick && ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ph     <= 1'b0;
         bitcnt <= '0;
         sclk   <= 1'b0;
         le     <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state  <= ST_SHIFT;
               ph     <= 1'b0;
               bitcnt <= '0;
            end
            ST_SHIFT: if (tick) begin
               if (!ph) begin
                  sclk <= 1'b1;
                  ph   <= 1'b1;
               end else begin
                  sclk <= 1'b0;
                  ph   <= 1'b0;
                  if (bitcnt == BCW'(WORD_W - 1)) begin
                     state <= ST_LE_HI;
                     le    <= 1'b1;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            ST_LE_HI: if (tick) begin
               ph <= ~ph;
               if (ph) begin
                  le    <= 1'b0;
                  state <= ST_LE_LO;
               end
            end
            ST_LE_LO: if (tick) begin
               ph <= ~ph;
               if (ph) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdw_word_writer.sv
module sdw_word_writer #(
   parameter int WORD_W      = 16,
   parameter int HALF_DIV    = 5,
   parameter int SYS_CLK_MHZ = 100,
   parameter int MIN_SCLK_NS = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              dac_sclk,
   output logic              dac_sdata,
   output logic              dac_le,
   output logic              word_done
);
   localparam int SCLK_PERIOD_NS = (2 * HALF_DIV * 1000) / SYS_CLK_MHZ;

   // R4: reject a divider that would run the serial clock too fast
   generate
      if (SCLK_PERIOD_NS < MIN_SCLK_NS || HALF_DIV < 1) begin : g_bad_div
         $error("serial clock period below minimum");
      end
      if (WORD_W < 2) begin : g_bad_width
         $error("word width too small");
      end
   endgenerate

   logic accept, tick, running, shifting, shift_en;

   assign accept = in_valid && in_ready;

   sdw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(running), .tick(tick)
   );

   sdw_sequencer #(.WORD_W(WORD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .tick(tick),
      .ready(in_ready), .running(running), .shifting(shifting),
      .shift_en(shift_en), .sclk(dac_sclk), .le(dac_le), .done(word_done)
   );

   sdw_shift_out #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .data(in_data),
      .shift(shift_en), .drive(shifting), .sdata(dac_sdata)
   );
endmodule

// File: rtl/sdw_word_writer_chk.sv
module sdw_word_writer_chk #(
   parameter int WORD_W   = 16,
   parameter int HALF_DIV = 5
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic dac_sclk,
   input logic dac_sdata,
   input logic dac_le,
   input logic word_done
);
   localparam int CW = $clog2(2 * HALF_DIV + 2) + 1;
   localparam int RW = $clog2(WORD_W + 1) + 1;

   logic [CW-1:0] hi_cnt, le_cnt;
   logic [RW-1:0] rises;
   logic          sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         le_cnt <= '0;
         rises  <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= dac_sclk;
         hi_cnt <= dac_sclk ? ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1) : '0;
         le_cnt <= dac_le ? ((&le_cnt) ? le_cnt : le_cnt + 1'b1) : '0;
         if (in_valid && in_ready)        rises <= '0;
         else if (dac_sclk && !sclk_q)    rises <= rises + 1'b1;
      end
   end

   assert_sclk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sclk) |-> hi_cnt == CW'(HALF_DIV));

   assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_sclk) |-> $stable(dac_sdata));

   assert_le_low_in_clocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sclk |-> !dac_le);

   assert_le_high_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_le) |-> le_cnt == CW'(2 * HALF_DIV));

   assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_le) |-> rises == RW'(WORD_W));

   assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_le || dac_sclk) |-> !in_ready);

   assert_done_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> (in_ready && !dac_le && !dac_sclk));
endmodule

bind sdw_word_writer sdw_word_writer_chk #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_le(dac_le),
   .word_done(word_done)
);

// File: tb/sdw_word_writer_tb.sv
module sdw_word_writer_tb;
   localparam int H = 5;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ready, dac_sclk, dac_sdata, dac_le, word_done;

   int checks = 0;
   int errors = 0;
   int words_seen = 0;
   logic [W-1:0] exp_q[$];

   always #5 clk = ~clk;

   sdw_word_writer #(.WORD_W(W), .HALF_DIV(H), .SYS_CLK_MHZ(100), .MIN_SCLK_NS(100)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .dac_sclk(dac_sclk), .dac_sdata(dac_sdata),
      .dac_le(dac_le), .word_done(word_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: decodes the serial link on falling clk edges
   initial begin
      logic [W-1:0] shreg = '0;
      int bits = 0, run_s = 0, run_l = 0;
      logic p_sclk = 1'b0, p_le = 1'b0, p_sd = 1'b0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (dac_sclk && !p_sclk) begin
            if (bits > 0) chk(run_s == H, "R4 low run", run_s, H);
            chk(p_sd == dac_sdata, "R5 data at rise", dac_sdata, p_sd);
            chk(!dac_le, "R6 le low during clock", dac_le, 0);
            shreg = {shreg[W-2:0], dac_sdata};
            bits++;
         end
         if (!dac_sclk && p_sclk) chk(run_s == H, "R4 high run", run_s, H);
         if (dac_le && !p_le) begin
            chk(bits == W, "R3 bits before le", bits, W);
            chk(!dac_sclk, "R6 sclk low at le rise", dac_sclk, 0);
         end
         if (!dac_le && p_le) begin
            chk(run_l == 2*H, "R6 le high time", run_l, 2*H);
            chk(bits == W, "R3 bit count", bits, W);
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", shreg, 0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(shreg == e, "R9 word value", shreg, e);
            end
            words_seen++;
            bits = 0;
         end
         run_s = (dac_sclk == p_sclk) ? run_s + 1 : 1;
         run_l = (dac_le == p_le) ? run_l + 1 : 1;
         p_sclk = dac_sclk; p_le = dac_le; p_sd = dac_sdata;
      end
   end

   task automatic send(input logic [W-1:0] word, input bit inject);
      int cyc;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = word;
      @(negedge clk);
      exp_q.push_back(word);
      in_valid = 1'b0;
      cyc = 0;
      chk(!in_ready, "R2 ready low after accept", in_ready, 0);
      if (inject) begin
         in_valid = 1'b1;
         in_data  = ~word;
      end
      while (!in_ready) begin
         @(negedge clk);
         cyc++;
         if (cyc == 3) in_valid = 1'b0;
      end
      chk(cyc == 36*H, "R7 ready return time", cyc, 36*H);
      chk(word_done, "R7 done pulse", word_done, 1);
      chk(!dac_sclk && !dac_le, "R8 parked lines", {dac_sclk, dac_le}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready && !dac_sclk && !dac_le && !dac_sdata && !word_done,
          "R1 reset state", {in_ready, dac_sclk, dac_le, dac_sdata, word_done}, 5'b10000);
      send(16'h7FFF, 1'b0);
      send(16'h8000, 1'b0);
      send(16'h0000, 1'b1);
      send(16'hFFFF, 1'b0);
      repeat (50) @(negedge clk);
      chk(!dac_sclk && !dac_le && !word_done, "R8 idle park", {dac_sclk, dac_le}, 0);
      send(16'hA5C3, 1'b1);
      send(16'h0001, 1'b0);
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
      chk(words_seen == 6, "R3 word count", words_seen, 6);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule